// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

This block holds two 8-bit up-counters, channel 0 and channel 1, each with its own compare register and a 3-bit clock-select field. A channel counts from a shared enable pulse (`tick_en`) at full rate, at one half or at one quarter of that rate, or it can take its count from the other channel. When channel 0 is clocked by channel 1's overflow, the pair forms one 16-bit timer: channel 1 is the low byte and channel 0 the high byte. When channel 1 is clocked by channel 0's compare match, channel 1 counts how many matches channel 0 has produced.

Everything runs in the single system clock domain. A chained increment is a one-cycle enable, not a derived clock, so a cascade event and the increment it causes land on the same clock edge. If both channels pick the chained source at once, neither has a real count source, so the block holds both counters. Compare-match and overflow events set sticky flags. Software clears each flag through a clear strobe. A single shared write port loads counters and compare registers.

Top module: `tmr8_pair`

## Requirements
- R1: After reset both counters read 0x00, both compare registers hold 0xFF, and every flag (`cmf`, `ovf`, `ovf16`) reads 0.
- R2: Clock-select codes: 3'b001 advances the counter by one on every cycle with `tick_en` high. 3'b010 advances it when `tick_en` is high and bit 0 of a shared 2-bit divider is 1. 3'b011 advances it when `tick_en` is high and both divider bits are 1. The divider resets to 0 and advances by one on each `tick_en`. Codes 3'b000, 3'b101, 3'b110 and 3'b111 stop the counter.
- R3: Channel 0 with code 3'b100 advances by one in exactly the cycles where channel 1 increments from 0xFF to 0x00, so `{cnt0,cnt1}` counts as one 16-bit value.
- R4: Channel 1 with code 3'b100 advances by one in exactly the cycles where channel 0 increments onto the value held in its compare register.
- R5: If both channels select code 3'b100, neither counter changes except through a counter write.
- R6: A counter write (`cnt_wr[i]`) loads `wr_data` and wins over an increment in the same cycle. That channel then produces no overflow or match event in that cycle, so nothing cascades from it. `cmp_wr[i]` loads the compare register, and the new value takes effect from the next cycle.
- R7: `cmf[i]` is set when counter i increments onto its compare value. It stays set until `cmf_clr[i]`, and a new match in the same cycle as the clear leaves it set.
- R8: `ovf[i]` is set when counter i increments from 0xFF to 0x00. It stays set until `ovf_clr[i]`, and a new overflow in the same cycle as the clear wins.
- R9: `ovf16` is set when channel 0, clocked by code 3'b100, wraps from 0xFF, which means the 16-bit value wraps from 0xFFFF to 0x0000. It clears on `ovf16_clr`, and a new wrap in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Base count enable pulse |
| cks0 | input | 3 | Channel 0 clock select |
| cks1 | input | 3 | Channel 1 clock select |
| cnt_wr | input | 2 | Counter write strobe per channel |
| cmp_wr | input | 2 | Compare register write strobe per channel |
| wr_data | input | 8 | Shared write data |
| cmf_clr | input | 2 | Compare-match flag clear per channel |
| ovf_clr | input | 2 | Overflow flag clear per channel |
| ovf16_clr | input | 1 | 16-bit overflow flag clear |
| cnt0 | output | 8 | Channel 0 counter (upper byte when chained) |
| cnt1 | output | 8 | Channel 1 counter (lower byte when chained) |
| cmf | output | 2 | Sticky compare-match flags |
| ovf | output | 2 | Sticky overflow flags |
| ovf16 | output | 1 | Sticky combined 16-bit overflow flag |

## Verification
The assertions assume that every input is a clean synchronous level, sampled on the rising clock edge. They also assume that a write strobe and a clear strobe each act for exactly the one cycle they are high. No assertion depends on the order of events within a cycle. The bench drives every input on the falling edge and never leaves a strobe high longer than intended, so these assumptions always hold.

Random clock-select codes include the reserved values and the illegal both-chained pairing. Compare values are drawn from a narrow range, and preloaded counters sit near 0xFF, so matches and wraps happen often instead of rarely.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CKS_W = 3;
  typedef enum logic [CKS_W-1:0] {
    CKS_OFF   = 3'b000,
    CKS_DIV1  = 3'b001,
    CKS_DIV2  = 3'b010,
    CKS_DIV4  = 3'b011,
    CKS_CHAIN = 3'b100
  } cks_e;
  localparam int DIV_W = 2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [DIV_W:0]   taps
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (tick_en) div_q <= div_q + 1'b1;
  end

  assign taps[0] = tick_en;
  for (genvar k = 1; k <= DIV_W; k++) begin : g_tap
    assign taps[k] = tick_en & (&div_q[k-1:0]);
  end

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(div_q));
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import tmr_pkg::*;
(
  input  logic [CKS_W-1:0] cks0,
  input  logic [CKS_W-1:0] cks1,
  input  logic [DIV_W:0]   taps,
  input  logic [1:0]       cnt_wr,
  input  logic             hit_nxt0,
  input  logic             wrap_nxt1,
  output logic [1:0]       inc,
  output logic             chain0_wrap
);
  function automatic logic base_fire(input logic [CKS_W-1:0] c, input logic [DIV_W:0] t);
    case (c)
      CKS_DIV1: base_fire = t[0];
      CKS_DIV2: base_fire = t[1];
      CKS_DIV4: base_fire = t[2];
      default:  base_fire = 1'b0;
    endcase
  endfunction

  logic base0, base1, chain0, chain1, lock;

  always_comb begin
    chain0 = (cks0 == CKS_CHAIN);
    chain1 = (cks1 == CKS_CHAIN);
    lock   = chain0 & chain1;
    base0  = base_fire(cks0, taps) & ~cnt_wr[0];
    base1  = base_fire(cks1, taps) & ~cnt_wr[1];
    // channel 1 chained on channel 0 match; channel 0 then runs from its base
    inc[1] = chain1 ? (~lock & base0 & hit_nxt0 & ~cnt_wr[1]) : base1;
    // channel 0 chained on channel 1 overflow; channel 1 then runs from its base
    inc[0] = chain0 ? (~lock & base1 & wrap_nxt1 & ~cnt_wr[0]) : base0;
    chain0_wrap = chain0;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] wr_data,
  input  logic         cmf_clr,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt,
  output logic         hit_nxt,
  output logic         wrap_nxt,
  output logic         ovf_evt,
  output logic         cmf,
  output logic         ovf
);
  logic [W-1:0] cmp_q, cnt_q, cnt_inc;
  logic         cmf_q, ovf_q, match_evt;

  assign cnt_inc   = cnt_q + 1'b1;
  assign hit_nxt   = (cnt_inc == cmp_q);
  assign wrap_nxt  = &cnt_q;
  assign match_evt = inc & hit_nxt;
  assign ovf_evt   = inc & wrap_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '1;
      cmf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (cnt_wr)   cnt_q <= wr_data;
      else if (inc) cnt_q <= cnt_inc;
      if (cmp_wr)   cmp_q <= wr_data;
      cmf_q <= (cmf_q & ~cmf_clr) | match_evt;
      ovf_q <= (ovf_q & ~ovf_clr) | ovf_evt;
    end
  end

  assign cnt = cnt_q;
  assign cmf = cmf_q;
  assign ovf = ovf_q;

  // R6
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(wr_data));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_inc)));
  // R7
  cmf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmf_q && !cmf_clr) |=> cmf_q);
  // R8
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !cnt_wr && (&cnt_q)) |=> (cnt_q == '0) && ovf_q);
endmodule

// File: rtl/tmr8_pair.sv
module tmr8_pair
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [2:0]       cks0,
  input  logic [2:0]       cks1,
  input  logic [1:0]       cnt_wr,
  input  logic [1:0]       cmp_wr,
  input  logic [W-1:0]     wr_data,
  input  logic [1:0]       cmf_clr,
  input  logic [1:0]       ovf_clr,
  input  logic             ovf16_clr,
  output logic [W-1:0]     cnt0,
  output logic [W-1:0]     cnt1,
  output logic [1:0]       cmf,
  output logic [1:0]       ovf,
  output logic             ovf16
);
  localparam int NCH = 2;

  logic [DIV_W:0]   taps;
  logic [NCH-1:0]   inc, hit_nxt, wrap_nxt, ovf_evt;
  logic [W-1:0]     cnt [NCH];
  logic             chain0;
  logic             ovf16_q;

  tmr_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .taps(taps)
  );

  tmr_src_sel u_sel (
    .cks0(cks0), .cks1(cks1), .taps(taps), .cnt_wr(cnt_wr),
    .hit_nxt0(hit_nxt[0]), .wrap_nxt1(wrap_nxt[1]),
    .inc(inc), .chain0_wrap(chain0)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_channel #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_n), .inc(inc[i]), .cnt_wr(cnt_wr[i]),
      .cmp_wr(cmp_wr[i]), .wr_data(wr_data), .cmf_clr(cmf_clr[i]),
      .ovf_clr(ovf_clr[i]), .cnt(cnt[i]), .hit_nxt(hit_nxt[i]),
      .wrap_nxt(wrap_nxt[i]), .ovf_evt(ovf_evt[i]), .cmf(cmf[i]), .ovf(ovf[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf16_q <= 1'b0;
    else        ovf16_q <= (ovf16_q & ~ovf16_clr) | (ovf_evt[0] & chain0);
  end

  assign cnt0  = cnt[0];
  assign cnt1  = cnt[1];
  assign ovf16 = ovf16_q;

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cks0 == CKS_CHAIN && cks1 == CKS_CHAIN && cnt_wr == 2'b00)
      |=> $stable(cnt0) && $stable(cnt1));
  // R3
  chain_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cks0 == CKS_CHAIN && cnt_wr == 2'b00 && cnt1 == '1) ##1 (cnt1 == '0)
      |-> cnt0 == $past(cnt0) + 1'b1);
  // R9
  ovf16_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf16_q && !ovf16_clr) |=> ovf16_q);
endmodule

// File: tb/tmr8_pair_tb.sv
module tmr8_pair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic [2:0] cks0 = 3'd0, cks1 = 3'd0;
  logic [1:0] cnt_wr = 2'b00, cmp_wr = 2'b00, cmf_clr = 2'b00, ovf_clr = 2'b00;
  logic [W-1:0] wr_data = '0;
  logic ovf16_clr = 1'b0;
  logic [W-1:0] cnt0, cnt1;
  logic [1:0] cmf, ovf;
  logic ovf16;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [W-1:0] m_cnt [2];
  logic [W-1:0] m_cmp [2];
  logic [1:0] m_cmf, m_ovf, m_div;
  logic m_ovf16;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr8_pair #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cks0(cks0), .cks1(cks1),
    .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .wr_data(wr_data), .cmf_clr(cmf_clr),
    .ovf_clr(ovf_clr), .ovf16_clr(ovf16_clr), .cnt0(cnt0), .cnt1(cnt1),
    .cmf(cmf), .ovf(ovf), .ovf16(ovf16)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic rate_fire(input logic [2:0] c, input logic t, input logic [1:0] d);
    case (c)
      3'b001:  return t;
      3'b010:  return t && d[0];
      3'b011:  return t && (d == 2'b11);
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt[0] = '0; m_cnt[1] = '0; m_cmp[0] = '1; m_cmp[1] = '1;
    m_cmf = '0; m_ovf = '0; m_div = '0; m_ovf16 = 1'b0;
  endtask

  // advance the reference by one clock using the present inputs
  task automatic model_step();
    logic r0, r1, both, i0, i1, o0, o1, h0, h1;
    both = (cks0 == 3'b100) && (cks1 == 3'b100);
    r0 = rate_fire(cks0, tick_en, m_div) && !cnt_wr[0];
    r1 = rate_fire(cks1, tick_en, m_div) && !cnt_wr[1];
    i1 = (cks1 == 3'b100) ? (!both && r0 && (W'(m_cnt[0] + 1) == m_cmp[0]) && !cnt_wr[1]) : r1;
    i0 = (cks0 == 3'b100) ? (!both && i1 && (m_cnt[1] == '1) && !cnt_wr[0]) : r0;
    o0 = i0 && (m_cnt[0] == '1);
    o1 = i1 && (m_cnt[1] == '1);
    h0 = i0 && (W'(m_cnt[0] + 1) == m_cmp[0]);
    h1 = i1 && (W'(m_cnt[1] + 1) == m_cmp[1]);
    m_cmf[0] = (m_cmf[0] && !cmf_clr[0]) || h0;
    m_cmf[1] = (m_cmf[1] && !cmf_clr[1]) || h1;
    m_ovf[0] = (m_ovf[0] && !ovf_clr[0]) || o0;
    m_ovf[1] = (m_ovf[1] && !ovf_clr[1]) || o1;
    m_ovf16 = (m_ovf16 && !ovf16_clr) || (o0 && cks0 == 3'b100);
    m_cnt[0] = cnt_wr[0] ? wr_data : (i0 ? W'(m_cnt[0] + 1) : m_cnt[0]);
    m_cnt[1] = cnt_wr[1] ? wr_data : (i1 ? W'(m_cnt[1] + 1) : m_cnt[1]);
    if (cmp_wr[0]) m_cmp[0] = wr_data;
    if (cmp_wr[1]) m_cmp[1] = wr_data;
    if (tick_en) m_div = m_div + 2'd1;
  endtask

  task automatic check_all();
    chk("R3", "cnt0", int'(cnt0), int'(m_cnt[0]));
    chk("R4", "cnt1", int'(cnt1), int'(m_cnt[1]));
    chk("R7", "cmf", int'(cmf), int'(m_cmf));
    chk("R8", "ovf", int'(ovf), int'(m_ovf));
    chk("R9", "ovf16", int'(ovf16), int'(m_ovf16));
  endtask

  // inputs are already set at a falling edge; step one clock and compare
  task automatic run_cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all();
    cnt_wr = '0; cmp_wr = '0; cmf_clr = '0; ovf_clr = '0; ovf16_clr = 1'b0;
  endtask

  task automatic write_cnt(input int ch, input logic [W-1:0] v);
    tick_en = 1'b0; cnt_wr[ch] = 1'b1; wr_data = v; run_cycle();
  endtask

  task automatic write_cmp(input int ch, input logic [W-1:0] v);
    tick_en = 1'b0; cmp_wr[ch] = 1'b1; wr_data = v; run_cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cnt0", int'(cnt0), 0);
    chk("R1", "cnt1", int'(cnt1), 0);
    chk("R1", "flags", int'({cmf, ovf, ovf16}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R9: 16-bit wrap from 0xFFFF
    write_cnt(0, 8'hFF); write_cnt(1, 8'hFF);
    cks0 = 3'b100; cks1 = 3'b001; tick_en = 1'b1; run_cycle();
    chk("R3", "16-bit wrap", int'({cnt0, cnt1}), 0);
    chk("R9", "ovf16 set", int'(ovf16), 1);
    ovf16_clr = 1'b1; tick_en = 1'b0; run_cycle();
    chk("R9", "ovf16 cleared", int'(ovf16), 0);

    // R5: both chained, counters frozen
    write_cnt(0, 8'hFE); write_cnt(1, 8'hFF);
    cks0 = 3'b100; cks1 = 3'b100; tick_en = 1'b1;
    repeat (8) run_cycle();
    chk("R5", "locked pair", int'({cnt0, cnt1}), 16'hFEFF);

    // R4: channel 1 counts channel 0 matches
    write_cmp(0, 8'h03); write_cnt(0, 8'h00); write_cnt(1, 8'h00);
    cks0 = 3'b001; cks1 = 3'b100; tick_en = 1'b1;
    repeat (3) run_cycle();
    chk("R4", "match count", int'(cnt1), 1);
    chk("R7", "cmf0 set", int'(cmf[0]), 1);

    // R6: write beats increment and suppresses the cascade
    write_cnt(0, 8'h02); tick_en = 1'b1; cnt_wr[0] = 1'b1; wr_data = 8'h40; run_cycle();
    chk("R6", "write priority", int'(cnt0), 8'h40);
    chk("R6", "no cascade", int'(cnt1), 1);

    // R2: divide-by-4 and reserved codes
    cks0 = 3'b011; cks1 = 3'b110; write_cnt(0, 8'h00); write_cnt(1, 8'h10);
    tick_en = 1'b1; repeat (8) run_cycle();
    chk("R2", "div4 count", int'(cnt0), 2);
    chk("R2", "reserved code holds", int'(cnt1), 8'h10);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 15) == 0) cks0 = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) cks1 = 3'($urandom_range(0, 7));
      tick_en = ($urandom_range(0, 3) != 0);
      wr_data = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(0, 7)) : 8'($urandom_range(8'hF8, 8'hFF));
      cnt_wr  = ($urandom_range(0, 31) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      cmp_wr  = ($urandom_range(0, 31) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      cmf_clr = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      ovf_clr = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      ovf16_clr = ($urandom_range(0, 7) == 0);
      run_cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule